// File: doc/BRIEF.md
# Microcontroller Data-Memory Space Router

This block sits between a small 8-bit CPU core and the on-chip data stores. For each data access it picks one of four physical stores: the lower RAM, the upper RAM, the special-function register (SFR) file, or an on-chip expanded RAM that occupies the bottom of the external data space. It can also send the access out to an external memory bus. The address alone does not decide the target. For bytes 80H–FFH, the upper RAM and the SFR file share addresses, and the access kind picks between them. A direct access reaches the SFR file. An indirect access reaches the upper RAM.

External-move accesses take either a 16-bit data pointer or an 8-bit register pointer. For an 8-bit pointer, the current port-2 SFR byte supplies the upper address byte. The expanded RAM serves an external-move access when two conditions hold: the enable control bit is 0 and the effective address lies below the window size. The external bus then stays quiet. Any other external-move access goes to the external bus, with an active-low strobe held for the cycle of the access.

Reads return their data one cycle later from a register. Writes take effect at the clock edge of the cycle in which they are presented.

Top module: `mem_space_router`

## Requirements
- R1: After reset, every byte of the lower RAM, upper RAM, expanded RAM and SFR file reads as 00H, except the port-2 SFR at direct address A0H, which reads FFH. After reset, rdata_o is 00H, both external strobes are high, ext_drive_o is low and ext_addr_o is FF00H.
- R2: Addresses 00H–7FH select the lower RAM for both direct (acc_kind_i = 0) and indirect (acc_kind_i = 1) accesses, and the two kinds reach the same bytes.
- R3: For addresses 80H–FFH, a direct access reaches the SFR file and an indirect access reaches the upper RAM. A write of either kind leaves the other store's byte at that address unchanged. This includes A0H, the port-2 SFR.
- R4: An external-move access (acc_kind_i = 2) with xram_off_i = 0 and an effective address below XRAM_BYTES (default 768, window 0000H–02FFH) reads or writes the expanded RAM. During that access ext_wr_n_o and ext_rd_n_o stay high and ext_drive_o stays low. Accesses that go to the external bus leave the expanded RAM unchanged.
- R5: Any other external-move access goes to the external bus. It drives ext_addr_o with the effective address and pulls ext_wr_n_o low (with ext_drive_o high and ext_wdata_o = wdata_i) or ext_rd_n_o low, in the same cycle as the request. A read then returns ext_rdata_i, as sampled in that cycle, on rdata_o.
- R6: With wide_ptr_i = 1 the effective external-move address is addr_i. With wide_ptr_i = 0 it is {port-2 SFR, addr_i[7:0]}, and this combined value decides whether the access falls inside the expanded-RAM window.
- R7: rdata_o shows the addressed byte in the cycle after rd_i is presented. A read presented in the cycle directly after a write to the same location returns the newly written byte.
- R8: In any cycle without an external-bus access, ext_addr_o is {port-2 SFR, 00H}, ext_wdata_o is 00H and ext_drive_o is low.
- R9: A cycle with wr_i high is a write, even when rd_i is also high, and it leaves rdata_o unchanged. Access kind 3 touches no store and no strobe. rdata_o changes only after a read that has a target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| acc_kind_i | input | 2 | 0 direct, 1 indirect, 2 external move, 3 none |
| wide_ptr_i | input | 1 | External move uses the 16-bit pointer when 1, the 8-bit register pointer when 0 |
| addr_i | input | 16 | Access address; only bits 7:0 are used unless a 16-bit pointer is selected |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| wdata_i | input | 8 | Write data |
| xram_off_i | input | 1 | 1 disables the on-chip expanded RAM |
| rdata_o | output | 8 | Registered read data |
| ext_addr_o | output | 16 | External bus address |
| ext_wdata_o | output | 8 | External bus write data |
| ext_drive_o | output | 1 | Drive enable for the external data bus |
| ext_wr_n_o | output | 1 | Active-low external write strobe |
| ext_rd_n_o | output | 1 | Active-low external read strobe |
| ext_rdata_i | input | 8 | External bus read data |

## Verification
The bench builds the router with its default XRAM_BYTES of 768. At that size, an 8-bit pointer with port-2 values 0 to 2 lands inside the expanded RAM and value 3 falls outside it, and the 02FFH/0300H edge is reachable with both pointer widths. The bench writes every direct and indirect byte address and every expanded-RAM byte, then reads each one back against a model of the four stores. A stand-in external memory returns a byte computed from the address, so data that actually comes from the bus can be told apart from data the on-chip RAM supplies.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int unsigned DW        = 8;
    localparam int unsigned AW        = 16;
    localparam int unsigned SEG_BYTES = 128;
    localparam int unsigned P2_SLOT   = 32;   // A0H - 80H

    typedef enum logic [1:0] {
        KIND_DIRECT   = 2'd0,
        KIND_INDIRECT = 2'd1,
        KIND_XMOVE    = 2'd2,
        KIND_NONE     = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_LOW  = 3'd1,
        TGT_UP   = 3'd2,
        TGT_SFR  = 3'd3,
        TGT_XRAM = 3'd4,
        TGT_EXT  = 3'd5
    } tgt_e;

endpackage

// File: rtl/msr_decode.sv
module msr_decode
    import msr_pkg::*;
#(
    parameter int unsigned XRAM_BYTES = 768
) (
    input  acc_kind_e         kind_i,
    input  logic              wide_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     p2_i,
    input  logic              xram_off_i,
    output tgt_e              tgt_o,
    output logic [AW-1:0]     ea_o
);

    localparam logic [AW:0] XLIMIT = (AW+1)'(XRAM_BYTES);

    always_comb begin
        tgt_o = TGT_NONE;
        ea_o  = {8'h00, addr_i[7:0]};
        unique case (kind_i)
            KIND_DIRECT:   tgt_o = addr_i[7] ? TGT_SFR : TGT_LOW;
            KIND_INDIRECT: tgt_o = addr_i[7] ? TGT_UP  : TGT_LOW;
            KIND_XMOVE: begin
                // narrow pointer borrows the port-2 latch as its high byte
                ea_o  = wide_i ? addr_i : {p2_i, addr_i[7:0]};
                tgt_o = (!xram_off_i && ({1'b0, ea_o} < XLIMIT)) ? TGT_XRAM : TGT_EXT;
            end
            default: tgt_o = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/msr_ram.sv
module msr_ram #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [IW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [IW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/msr_sfr_file.sv
module msr_sfr_file
    import msr_pkg::*;
#(
    parameter logic [DW-1:0] P2_RESET = 8'hFF
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [6:0]    waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [6:0]    raddr_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] p2_o
);

    logic [DW-1:0] reg_d [SEG_BYTES];
    logic [DW-1:0] reg_q [SEG_BYTES];

    always_comb begin
        reg_d = reg_q;
        if (we_i) begin
            reg_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(SEG_BYTES); i++) begin
                reg_q[i] <= (i == int'(P2_SLOT)) ? P2_RESET : '0;
            end
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata_o = reg_q[raddr_i];
    assign p2_o    = reg_q[P2_SLOT];

endmodule

// File: rtl/mem_space_router.sv
module mem_space_router
    import msr_pkg::*;
#(
    parameter int unsigned XRAM_BYTES = 768,
    localparam int unsigned XIW       = $clog2(XRAM_BYTES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    acc_kind_i,
    input  logic          wide_ptr_i,
    input  logic [15:0]   addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [7:0]    wdata_i,
    input  logic          xram_off_i,
    output logic [7:0]    rdata_o,
    output logic [15:0]   ext_addr_o,
    output logic [7:0]    ext_wdata_o,
    output logic          ext_drive_o,
    output logic          ext_wr_n_o,
    output logic          ext_rd_n_o,
    input  logic [7:0]    ext_rdata_i
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    tgt_e          tgt;
    logic [AW-1:0] ea;
    logic [DW-1:0] p2;
    logic [DW-1:0] low_rd, up_rd, sfr_rd, x_rd;
    logic          do_wr, do_rd, ext_hit;

    assign do_wr = wr_i;
    assign do_rd = rd_i && !wr_i;

    msr_decode #(.XRAM_BYTES(XRAM_BYTES)) u_dec (
        .kind_i     (acc_kind_e'(acc_kind_i)),
        .wide_i     (wide_ptr_i),
        .addr_i     (addr_i),
        .p2_i       (p2),
        .xram_off_i (xram_off_i),
        .tgt_o      (tgt),
        .ea_o       (ea)
    );

    msr_ram #(.DEPTH(SEG_BYTES), .WIDTH(DW)) u_low (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (do_wr && (tgt == TGT_LOW)),
        .waddr_i (ea[6:0]),
        .wdata_i (wdata_i),
        .raddr_i (ea[6:0]),
        .rdata_o (low_rd)
    );

    msr_ram #(.DEPTH(SEG_BYTES), .WIDTH(DW)) u_up (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (do_wr && (tgt == TGT_UP)),
        .waddr_i (ea[6:0]),
        .wdata_i (wdata_i),
        .raddr_i (ea[6:0]),
        .rdata_o (up_rd)
    );

    msr_sfr_file u_sfr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (do_wr && (tgt == TGT_SFR)),
        .waddr_i (ea[6:0]),
        .wdata_i (wdata_i),
        .raddr_i (ea[6:0]),
        .rdata_o (sfr_rd),
        .p2_o    (p2)
    );

    msr_ram #(.DEPTH(XRAM_BYTES), .WIDTH(DW)) u_xram (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (do_wr && (tgt == TGT_XRAM)),
        .waddr_i (ea[XIW-1:0]),
        .wdata_i (wdata_i),
        .raddr_i (ea[XIW-1:0]),
        .rdata_o (x_rd)
    );

    assign ext_hit = (tgt == TGT_EXT) && (rd_i || wr_i);

    always_comb begin
        st_d = st_q;
        if (do_rd) begin
            unique case (tgt)
                TGT_LOW:  st_d.rdata = low_rd;
                TGT_UP:   st_d.rdata = up_rd;
                TGT_SFR:  st_d.rdata = sfr_rd;
                TGT_XRAM: st_d.rdata = x_rd;
                TGT_EXT:  st_d.rdata = ext_rdata_i;
                default:  st_d.rdata = st_q.rdata;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o     = st_q.rdata;
    assign ext_addr_o  = ext_hit ? ea : {p2, 8'h00};
    assign ext_drive_o = ext_hit && do_wr;
    assign ext_wdata_o = (ext_hit && do_wr) ? wdata_i : 8'h00;
    assign ext_wr_n_o  = !(ext_hit && do_wr);
    assign ext_rd_n_o  = !(ext_hit && do_rd);

endmodule

// File: rtl/msr_router_chk.sv
module msr_router_chk #(
    parameter int unsigned XRAM_BYTES = 768
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [1:0]  acc_kind_i,
    input logic        wide_ptr_i,
    input logic [15:0] addr_i,
    input logic        rd_i,
    input logic        wr_i,
    input logic        xram_off_i,
    input logic [7:0]  rdata_o,
    input logic [15:0] ext_addr_o,
    input logic        ext_drive_o,
    input logic        ext_wr_n_o,
    input logic        ext_rd_n_o,
    input logic [7:0]  ext_rdata_i
);

    localparam logic [16:0] LIMIT = 17'(XRAM_BYTES);

    assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!ext_wr_n_o && !ext_rd_n_o));

    assert_drive_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_drive_o |-> !ext_wr_n_o);

    assert_ext_read_return_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ext_rd_n_o |=> (rdata_o == $past(ext_rdata_i)));

    assert_onchip_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_kind_i == 2'd2 && wide_ptr_i && !xram_off_i && ({1'b0, addr_i} < LIMIT)
         && (rd_i || wr_i))
        |-> (ext_wr_n_o && ext_rd_n_o && !ext_drive_o));

    assert_idle_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_wr_n_o && ext_rd_n_o) |-> (ext_addr_o[7:0] == 8'h00 && !ext_drive_o));

    assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_i && !wr_i) |=> $stable(rdata_o));

    assert_internal_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_kind_i != 2'd2) |-> (ext_wr_n_o && ext_rd_n_o));

endmodule

bind mem_space_router msr_router_chk #(.XRAM_BYTES(XRAM_BYTES)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_kind_i  (acc_kind_i),
    .wide_ptr_i  (wide_ptr_i),
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .xram_off_i  (xram_off_i),
    .rdata_o     (rdata_o),
    .ext_addr_o  (ext_addr_o),
    .ext_drive_o (ext_drive_o),
    .ext_wr_n_o  (ext_wr_n_o),
    .ext_rd_n_o  (ext_rd_n_o),
    .ext_rdata_i (ext_rdata_i)
);

// File: tb/sim_mem_space_router.sv
`timescale 1ns/1ps
module sim_mem_space_router;

    localparam int XB = 768;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic        wide = 1'b0;
    logic [15:0] addr = 16'h0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = 8'h0;
    logic        xoff = 1'b0;
    logic [7:0]  rdata, ext_wdata, ext_rdata;
    logic [15:0] ext_addr;
    logic        ext_drive, ext_wr_n, ext_rd_n;

    always #4 clk = ~clk;

    // stand-in external memory: data is a function of the address
    assign ext_rdata = ext_addr[7:0] ^ ext_addr[15:8] ^ 8'hA5;

    mem_space_router #(.XRAM_BYTES(XB)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .acc_kind_i(kind), .wide_ptr_i(wide),
        .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .xram_off_i(xoff),
        .rdata_o(rdata), .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata),
        .ext_drive_o(ext_drive), .ext_wr_n_o(ext_wr_n), .ext_rd_n_o(ext_rd_n),
        .ext_rdata_i(ext_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_low [128];
    logic [7:0] m_up  [128];
    logic [7:0] m_sfr [128];
    logic [7:0] m_x   [XB];

    function automatic logic [7:0] ext_pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [15:0] xea(input logic w16, input logic [15:0] a);
        return w16 ? a : {m_sfr[32], a[7:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic put(input logic [1:0] k, input logic w16, input logic [15:0] a,
                       input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        kind = k; wide = w16; addr = a; rd = r; wr = w; wdata = d;
        #1;
    endtask

    task automatic idle();
        put(2'd0, 1'b0, 16'h0, 1'b0, 1'b0, 8'h0);
    endtask

    task automatic rd_any(input logic [1:0] k, input logic w16, input logic [15:0] a,
                          output logic [7:0] q);
        put(k, w16, a, 1'b1, 1'b0, 8'h0);
        idle();
        q = rdata;
    endtask

    task automatic wr_dir(input logic [7:0] a, input logic [7:0] d);
        put(2'd0, 1'b0, {8'h0, a}, 1'b0, 1'b1, d);
        if (a[7]) m_sfr[a[6:0]] = d; else m_low[a[6:0]] = d;
    endtask

    task automatic wr_ind(input logic [7:0] a, input logic [7:0] d);
        put(2'd1, 1'b0, {8'h0, a}, 1'b0, 1'b1, d);
        if (a[7]) m_up[a[6:0]] = d; else m_low[a[6:0]] = d;
    endtask

    task automatic wr_x(input logic w16, input logic [15:0] a, input logic [7:0] d);
        logic [15:0] ea;
        ea = xea(w16, a);
        put(2'd2, w16, a, 1'b0, 1'b1, d);
        if (!xoff && int'(ea) < XB) begin
            check("R4 on-chip write keeps bus quiet", {13'h0, ext_wr_n, ext_rd_n, ext_drive}, 16'h6);
            m_x[ea] = d;
        end else begin
            check("R5 external write strobes", {13'h0, ext_wr_n, ext_rd_n, ext_drive}, 16'h3);
            check("R6 external write address", ext_addr, ea);
            check("R5 external write data", {8'h0, ext_wdata}, {8'h0, d});
        end
    endtask

    task automatic rd_x(input logic w16, input logic [15:0] a);
        logic [15:0] ea;
        logic [7:0]  exp;
        logic        onchip;
        ea = xea(w16, a);
        onchip = !xoff && int'(ea) < XB;
        exp = onchip ? m_x[ea] : ext_pat(ea);
        put(2'd2, w16, a, 1'b1, 1'b0, 8'h0);
        if (onchip) begin
            check("R4 on-chip read keeps bus quiet", {13'h0, ext_wr_n, ext_rd_n, ext_drive}, 16'h6);
        end else begin
            check("R5 external read strobes", {13'h0, ext_wr_n, ext_rd_n, ext_drive}, 16'h4);
            check("R6 external read address", ext_addr, ea);
        end
        idle();
        check(onchip ? "R4 expanded RAM read data" : "R5 external read data",
              {8'h0, rdata}, {8'h0, exp});
    endtask

    initial begin
        logic [7:0] q, prev;
        for (int i = 0; i < 128; i++) begin
            m_low[i] = 8'h0; m_up[i] = 8'h0; m_sfr[i] = 8'h0;
        end
        m_sfr[32] = 8'hFF;
        for (int i = 0; i < XB; i++) m_x[i] = 8'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        check("R1 rdata after reset", {8'h0, rdata}, 16'h0);
        check("R1 strobes after reset", {13'h0, ext_wr_n, ext_rd_n, ext_drive}, 16'h6);
        check("R1 R8 idle address after reset", ext_addr, 16'hFF00);
        rd_any(2'd0, 1'b0, 16'h00A0, q); check("R1 port-2 SFR reset", {8'h0, q}, 16'h00FF);
        rd_any(2'd1, 1'b0, 16'h00A0, q); check("R1 upper RAM reset", {8'h0, q}, 16'h0);
        rd_any(2'd0, 1'b0, 16'h0005, q); check("R1 lower RAM reset", {8'h0, q}, 16'h0);
        rd_x(1'b1, 16'h0100);

        // R2 R3 sweep of direct and indirect spaces
        for (int a = 0; a < 256; a++) wr_dir(8'(a), 8'(a * 7 + 3));
        for (int a = 128; a < 256; a++) wr_ind(8'(a), 8'(a) ^ 8'hC3);
        for (int a = 0; a < 256; a++) begin
            rd_any(2'd0, 1'b0, 16'(a), q);
            check(a < 128 ? "R2 direct lower read" : "R3 direct SFR read", {8'h0, q},
                  {8'h0, (a < 128) ? m_low[a] : m_sfr[a - 128]});
        end
        for (int a = 0; a < 256; a++) begin
            rd_any(2'd1, 1'b0, 16'(a), q);
            check(a < 128 ? "R2 indirect lower read" : "R3 indirect upper read", {8'h0, q},
                  {8'h0, (a < 128) ? m_low[a] : m_up[a - 128]});
        end

        // R3 port-2 separation, R8 idle high byte follows port-2
        wr_dir(8'hA0, 8'h00);
        wr_ind(8'hA0, 8'h5E);
        idle();
        check("R8 idle address shows port-2", ext_addr, 16'h0000);
        rd_any(2'd0, 1'b0, 16'h00A0, q); check("R3 port-2 SFR untouched by indirect write", {8'h0, q}, 16'h0);
        rd_any(2'd1, 1'b0, 16'h00A0, q); check("R3 upper RAM at A0", {8'h0, q}, 16'h005E);

        // R4 R5 R6 narrow-pointer writes across port-2 pages 0..3
        for (int pg = 0; pg < 4; pg++) begin
            wr_dir(8'hA0, 8'(pg));
            for (int r = 0; r < 256; r++) wr_x(1'b0, 16'(r), 8'(r) ^ 8'(pg) ^ 8'h96);
        end

        // R4 R6 wide-pointer read of whole window
        for (int a = 0; a < XB; a++) rd_x(1'b1, 16'(a));

        // R6 narrow-pointer reads
        wr_dir(8'hA0, 8'h02);
        for (int r = 0; r < 256; r++) rd_x(1'b0, 16'(r));
        wr_dir(8'hA0, 8'h03);
        rd_x(1'b0, 16'h0010);
        rd_x(1'b0, 16'h00FF);

        // R4 R5 window edge
        wr_x(1'b1, 16'h02FF, 8'h3C);
        wr_x(1'b1, 16'h0300, 8'h4D);
        rd_x(1'b1, 16'h02FF);
        rd_x(1'b1, 16'h0300);
        rd_x(1'b1, 16'hFFFF);

        // R5 R4 control bit set sends low addresses out, RAM keeps its byte
        xoff = 1'b1;
        wr_x(1'b1, 16'h0010, 8'hEE);
        rd_x(1'b1, 16'h0010);
        xoff = 1'b0;
        rd_x(1'b1, 16'h0010);

        // R7 write then read in the following cycle
        put(2'd2, 1'b1, 16'h0123, 1'b0, 1'b1, 8'hB7);
        m_x[16'h0123] = 8'hB7;
        put(2'd2, 1'b1, 16'h0123, 1'b1, 1'b0, 8'h0);
        idle();
        check("R7 back-to-back expanded RAM", {8'h0, rdata}, 16'h00B7);
        put(2'd0, 1'b0, 16'h0033, 1'b0, 1'b1, 8'h6A);
        m_low[16'h33] = 8'h6A;
        put(2'd1, 1'b0, 16'h0033, 1'b1, 1'b0, 8'h0);
        idle();
        check("R7 back-to-back lower RAM", {8'h0, rdata}, 16'h006A);

        // R9 write wins over read, kind 3 is inert
        rd_any(2'd0, 1'b0, 16'h0040, prev);
        put(2'd0, 1'b0, 16'h0040, 1'b1, 1'b1, 8'h99);
        m_low[16'h40] = 8'h99;
        idle();
        check("R9 rdata held on read+write", {8'h0, rdata}, {8'h0, prev});
        rd_any(2'd0, 1'b0, 16'h0040, q); check("R9 write performed", {8'h0, q}, 16'h0099);
        put(2'd3, 1'b0, 16'h0040, 1'b0, 1'b1, 8'h11);
        check("R9 kind 3 no strobe", {13'h0, ext_wr_n, ext_rd_n, ext_drive}, 16'h6);
        put(2'd3, 1'b0, 16'h0040, 1'b1, 1'b0, 8'h0);
        idle();
        check("R9 kind 3 read leaves rdata", {8'h0, rdata}, 16'h0099);
        rd_any(2'd0, 1'b0, 16'h0040, q); check("R9 kind 3 write ignored", {8'h0, q}, 16'h0099);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule